// File: doc/BRIEF.md
# Receive quiesce reset sequencer

This block resets a downstream packet engine that trades credits with a multi-port MAC receive path, without losing credits while traffic is flowing. When a request is accepted, it first turns off receive on every port, then waits a fixed settle time so that data already in flight can drain. Next it raises a single global path reset that stops every port's receive FIFO from pushing data. The downstream engine reset is pulsed only while that path reset is held.

After the engine reset ends, the path reset is cleared first. Receive is then turned back on for exactly the ports that were enabled when the request was taken, and a one-cycle done pulse marks the end. Outside a sequence, the per-port receive enables follow the enabled-port bitmap. The transmit enables pass straight through and are never touched by the sequence.

The settle time is given in microseconds and converted to cycles from the clock frequency; the default is 1 ms. The engine reset width is a parameter with a floor of 16 cycles.

Top module: `rqs_top`

## Requirements
- R1: In the cycle after a request is accepted, every bit of rx_en_o is 0, and it stays 0 until the restore cycle of R5.
- R2: path_rst_o rises exactly SETTLE cycles after the first cycle with receive off. With the first receive-off cycle numbered 0, path_rst_o is 1 first in cycle SETTLE, where SETTLE = CLK_MHZ*SETTLE_US.
- R3: path_rst_o stays high for PULSE+2 consecutive cycles, from cycle SETTLE to cycle SETTLE+PULSE+1.
- R4: eng_rst_o is 1 only while path_rst_o is 1, and it rises one cycle after path_rst_o rises (cycle SETTLE+1).
- R5: path_rst_o falls one cycle after eng_rst_o falls. In the cycle it falls (SETTLE+PULSE+2), rx_en_o is still all 0. In the next cycle (SETTLE+PULSE+3), rx_en_o is restored and done_o is 1.
- R6: tx_en_o equals tx_en_i delayed by one cycle at all times, during a sequence as well as outside one.
- R7: eng_rst_o is high for exactly PULSE consecutive cycles, where PULSE = max(ENG_RST_CYC, 16).
- R8: The restore cycle drives rx_en_o with the port_en_i value sampled when the request was accepted, even if port_en_i changed during the sequence. done_o is high for that single cycle.
- R9: A req_i that is high while a sequence is in progress is ignored. The timeline of the running sequence is unchanged, and no second sequence or extra done pulse follows.
- R10: While rst is high, and in the first cycle after it, every output is 0.
- R11: While idle (also in the cycle after done), rx_en_o equals port_en_i delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Start request, sampled while idle |
| port_en_i | input | NPORT | Enabled-port bitmap |
| tx_en_i | input | NPORT | Per-port transmit enable, passed through |
| rx_en_o | output | NPORT | Per-port MAC receive enable |
| tx_en_o | output | NPORT | Per-port transmit enable, registered |
| path_rst_o | output | 1 | Global push block for all receive FIFOs |
| eng_rst_o | output | 1 | Downstream engine reset |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
Full sequences run with random enabled-port bitmaps, including all-zero and all-one masks. During each sequence the bitmap is flipped, so a restore from the live input can be told apart from a restore from the captured mask. Some sequences add random requests while busy; a restart or a second done would shift the expected timeline. Transmit enables toggle randomly throughout, so any coupling between the sequence and the transmit path shows up. Idle-phase bitmap changes check that receive follows the bitmap with one cycle of delay.

// File: rtl/rqs_pkg.sv
package rqs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_BLOCK,
    ST_ENGRST,
    ST_HOLD,
    ST_RELEASE,
    ST_REEN
  } rqs_state_e;

  typedef enum logic [1:0] {
    RX_FOLLOW,
    RX_OFF,
    RX_RESTORE
  } rqs_rx_mode_e;

  function automatic int rqs_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rqs_timer.sv
module rqs_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/rqs_fsm.sv
module rqs_fsm
  import rqs_pkg::*;
#(
  parameter int SETTLE = 125000,
  parameter int PULSE  = 16,
  parameter int CW     = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          capture,
  output rqs_rx_mode_e  rx_mode,
  output logic          path_rst_q,
  output logic          eng_rst_q,
  output logic          done_q
);

  localparam logic [CW-1:0] SETTLE_LD = CW'(SETTLE - 1);
  localparam logic [CW-1:0] PULSE_LD  = CW'(PULSE - 1);

  rqs_state_e state_q, state_nxt;

  always_comb begin
    state_nxt = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    capture   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          state_nxt = ST_DRAIN;
          tmr_load  = 1'b1;
          tmr_val   = SETTLE_LD;
          capture   = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (tmr_zero) state_nxt = ST_BLOCK;
      end
      ST_BLOCK: begin
        state_nxt = ST_ENGRST;
        tmr_load  = 1'b1;
        tmr_val   = PULSE_LD;
      end
      ST_ENGRST: begin
        if (tmr_zero) state_nxt = ST_HOLD;
      end
      ST_HOLD:    state_nxt = ST_RELEASE;
      ST_RELEASE: state_nxt = ST_REEN;
      ST_REEN:    state_nxt = ST_IDLE;
      default:    state_nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_nxt)
      ST_IDLE: rx_mode = RX_FOLLOW;
      ST_REEN: rx_mode = RX_RESTORE;
      default: rx_mode = RX_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      path_rst_q <= 1'b0;
      eng_rst_q  <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_nxt;
      path_rst_q <= (state_nxt == ST_BLOCK) || (state_nxt == ST_ENGRST) ||
                    (state_nxt == ST_HOLD);
      eng_rst_q  <= (state_nxt == ST_ENGRST);
      done_q     <= (state_nxt == ST_REEN);
    end
  end

endmodule

// File: rtl/rqs_port_gate.sv
module rqs_port_gate
  import rqs_pkg::*;
#(
  parameter int NPORT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  rqs_rx_mode_e     rx_mode,
  input  logic [NPORT-1:0] port_en,
  input  logic [NPORT-1:0] tx_en,
  output logic [NPORT-1:0] rx_en_q,
  output logic [NPORT-1:0] tx_en_q
);

  logic [NPORT-1:0] mask_q;

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[i]  <= 1'b0;
        rx_en_q[i] <= 1'b0;
        tx_en_q[i] <= 1'b0;
      end else begin
        if (capture) mask_q[i] <= port_en[i];
        tx_en_q[i] <= tx_en[i];
        unique case (rx_mode)
          RX_FOLLOW:  rx_en_q[i] <= port_en[i];
          RX_RESTORE: rx_en_q[i] <= mask_q[i];
          default:    rx_en_q[i] <= 1'b0;
        endcase
      end
    end
  end

endmodule

// File: rtl/rqs_top.sv
module rqs_top
  import rqs_pkg::*;
#(
  parameter int NPORT       = 8,
  parameter int CLK_MHZ     = 125,
  parameter int SETTLE_US   = 1000,
  parameter int ENG_RST_CYC = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic [NPORT-1:0] port_en_i,
  input  logic [NPORT-1:0] tx_en_i,
  output logic [NPORT-1:0] rx_en_o,
  output logic [NPORT-1:0] tx_en_o,
  output logic             path_rst_o,
  output logic             eng_rst_o,
  output logic             done_o
);

  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
  localparam int PULSE_CYC  = (ENG_RST_CYC < 16) ? 16 : ENG_RST_CYC;
  localparam int CW         = $clog2(rqs_max(SETTLE_CYC, PULSE_CYC) + 1);

  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;
  logic          capture;
  rqs_rx_mode_e  rx_mode;

  rqs_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  rqs_fsm #(.SETTLE(SETTLE_CYC), .PULSE(PULSE_CYC), .CW(CW)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req        (req_i),
    .tmr_zero   (tmr_zero),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .capture    (capture),
    .rx_mode    (rx_mode),
    .path_rst_q (path_rst_o),
    .eng_rst_q  (eng_rst_o),
    .done_q     (done_o)
  );

  rqs_port_gate #(.NPORT(NPORT)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .capture (capture),
    .rx_mode (rx_mode),
    .port_en (port_en_i),
    .tx_en   (tx_en_i),
    .rx_en_q (rx_en_o),
    .tx_en_q (tx_en_o)
  );

endmodule

// File: rtl/rqs_chk.sv
module rqs_chk #(
  parameter int NPORT = 8,
  parameter int PULSE = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [NPORT-1:0] tx_en_i,
  input logic [NPORT-1:0] rx_en_o,
  input logic [NPORT-1:0] tx_en_o,
  input logic             path_rst_o,
  input logic             eng_rst_o,
  input logic             done_o
);

  localparam int EW = $clog2(PULSE + 2) + 1;
  logic [EW-1:0] ecnt;

  always_ff @(posedge clk) begin
    if (rst) ecnt <= '0;
    else if (eng_rst_o) begin
      if (ecnt != '1) ecnt <= ecnt + 1'b1;
    end else ecnt <= '0;
  end

  AST_RX_OFF_IN_PATH: assert property (@(posedge clk) disable iff (rst)
    path_rst_o |-> (rx_en_o == '0)); // R1
  AST_ENG_IN_PATH: assert property (@(posedge clk) disable iff (rst)
    eng_rst_o |-> path_rst_o); // R4
  AST_ENG_AFTER_PATH: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_rst_o) |-> $past(path_rst_o)); // R4
  AST_PATH_CLEAR_FIRST: assert property (@(posedge clk) disable iff (rst)
    $fell(path_rst_o) |-> (rx_en_o == '0) && !done_o && $past(!eng_rst_o)); // R5
  AST_DONE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(path_rst_o) |=> done_o); // R5
  AST_ENG_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(eng_rst_o) |-> (ecnt == EW'(PULSE))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8
  AST_TX_PASS: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (tx_en_o == $past(tx_en_i))); // R6

endmodule

bind rqs_top rqs_chk #(.NPORT(NPORT), .PULSE(PULSE_CYC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tx_en_i    (tx_en_i),
  .rx_en_o    (rx_en_o),
  .tx_en_o    (tx_en_o),
  .path_rst_o (path_rst_o),
  .eng_rst_o  (eng_rst_o),
  .done_o     (done_o)
);

// File: tb/tb_rqs_top.sv
`timescale 1ns/1ps
module tb_rqs_top;

  localparam int NP = 8;
  localparam int S  = 125;  // CLK_MHZ 125 * SETTLE_US 1
  localparam int P  = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_i = 1'b0;
  logic [NP-1:0] port_en_i = '0;
  logic [NP-1:0] tx_en_i = '0;
  logic [NP-1:0] rx_en_o, tx_en_o;
  logic          path_rst_o, eng_rst_o, done_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  rqs_top #(.NPORT(NP), .CLK_MHZ(125), .SETTLE_US(1), .ENG_RST_CYC(P)) dut (
    .clk(clk), .rst(rst), .req_i(req_i), .port_en_i(port_en_i),
    .tx_en_i(tx_en_i), .rx_en_o(rx_en_o), .tx_en_o(tx_en_o),
    .path_rst_o(path_rst_o), .eng_rst_o(eng_rst_o), .done_o(done_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [NP-1:0] exp_rx(input int c, input logic [NP-1:0] m,
                                           input logic [NP-1:0] live);
    if (c < S + P + 3) return '0;
    if (c == S + P + 3) return m;
    return live;
  endfunction

  function automatic logic exp_path(input int c);
    return (c >= S) && (c <= S + P + 1);
  endfunction

  function automatic logic exp_eng(input int c);
    return (c >= S + 1) && (c <= S + P);
  endfunction

  task automatic do_seq(input logic [NP-1:0] mask, input bit busy);
    logic [NP-1:0] live;
    live = ~mask;
    req_i = 1'b1;
    port_en_i = mask;
    tx_en_i = NP'($urandom);
    @(posedge clk);
    for (int c = 0; c <= S + P + 4; c++) begin
      @(negedge clk);
      chk("R1/R8/R11 rx_en", 32'(rx_en_o), 32'(exp_rx(c, mask, live)));
      chk("R2/R3 path_rst", 32'(path_rst_o), 32'(exp_path(c)));
      chk("R4/R7 eng_rst", 32'(eng_rst_o), 32'(exp_eng(c)));
      chk("R5/R9 done", 32'(done_o), 32'(c == S + P + 3));
      chk("R6 tx_en", 32'(tx_en_o), 32'(tx_en_i));
      req_i = busy && (c < S + P + 2) && ($urandom % 3 == 0);
      if (c == 0) port_en_i = live;
      tx_en_i = NP'($urandom);
    end
    req_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    tx_en_i = 8'hA5;
    port_en_i = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 rx in reset", 32'(rx_en_o), 0);
    chk("R10 path in reset", 32'(path_rst_o), 0);
    chk("R10 eng in reset", 32'(eng_rst_o), 0);
    chk("R10 done in reset", 32'(done_o), 0);
    chk("R10 tx in reset", 32'(tx_en_o), 0);
    rst = 1'b0;
    port_en_i = '0;
    tx_en_i = '0;
    @(negedge clk);
    chk("R10 rx after reset", 32'(rx_en_o), 0);
    chk("R10 done after reset", 32'(done_o), 0);

    // R11 idle follow
    for (int k = 0; k < 6; k++) begin
      port_en_i = NP'($urandom);
      tx_en_i = NP'($urandom);
      @(negedge clk);
      chk("R11 idle rx follow", 32'(rx_en_o), 32'(port_en_i));
      chk("R6 idle tx", 32'(tx_en_o), 32'(tx_en_i));
      chk("R11 idle path", 32'(path_rst_o), 0);
    end

    // directed corners
    do_seq(8'hFF, 1'b0);
    do_seq(8'h00, 1'b0);
    do_seq(8'h5A, 1'b1);  // R9 busy requests
    // random sequences, some back to back
    for (int k = 0; k < 8; k++) begin
      do_seq(NP'($urandom), bit'($urandom % 2));
      if (k % 2 == 1) begin
        port_en_i = NP'($urandom);
        @(negedge clk);
        chk("R11 rx after done", 32'(rx_en_o), 32'(port_en_i));
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule